// File: doc/BRIEF.md
# Four-Phase Accumulator Processor Controller

This block is the control core of a minimal sequential processor. It holds one 16-bit accumulator, a program counter and an instruction register. Code and data share one memory, which sits outside the block. Every instruction takes a fixed four-step walk: fetch, decode, prepare and execute. A phase generator sequences the steps. A decoder turns the current phase and opcode into single-cycle strobes: address select, instruction load, counter increment, counter load, ALU operation latch, and the accumulator load, shift and clear controls.

The block reaches memory through one address port. A mux drives that port with either the program counter or the 12-bit address field of the current instruction. Memory reads are expected within the same cycle. Writes take effect on the clock edge on which `mem_we` is high. A halt opcode freezes the sequencer and raises `halted`, so a harness can inspect the accumulator and memory afterwards.

Instruction word: bits 15:12 hold the opcode and bits 11:0 hold the address field.

Top module: `cpu4_core`

## Requirements
- R1: Each instruction other than halt spends exactly one cycle in each phase, in the order fetch, decode, prepare, execute, and then returns to fetch. In a straight run where the k-th executed instruction (counting from 0) is a halt, `halted` is first high after 4k+2 rising edges following reset release.
- R2: During fetch, `mem_addr` equals the program counter, which is 0 in the first cycle after reset. The word read in that cycle becomes the instruction.
- R3: From decode through execute, `mem_addr` equals bits 11:0 of the instruction. The program counter advances by one during decode.
- R4: Opcode 0 (add) sets the accumulator to accumulator + M[addr], wrapped to 16 bits.
- R5: Opcode 1 (jump) loads the program counter with the address field, so execution continues at that word.
- R6: Opcode 2 shifts the accumulator right by one and opcode 3 shifts it left by one, both filling with 0. Opcode 4 clears the accumulator to 0.
- R7: Opcode 5 loads the accumulator from M[addr]. Opcode 6 raises `mem_we` for exactly one cycle, in execute, with `mem_wdata` equal to the accumulator. No other opcode writes memory.
- R8: Opcode 7 jumps to the address field only when the accumulator is 0. Otherwise execution continues at the next word.
- R9: Opcode 15 (halt) makes `halted` go high and stay high. After that, the accumulator holds its value and `mem_we` stays low until reset.
- R10: Opcodes 8 to 14 change neither the accumulator nor memory.
- R11: While `rst` is high at a clock edge, the program counter, instruction and accumulator are cleared and the sequencer returns to fetch. `acc_out` reads 0, `mem_addr` reads 0 and `halted` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Shared code/data memory address |
| mem_rdata | input | 16 | Memory read data for `mem_addr`, valid in the same cycle |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_we | output | 1 | Memory write strobe, applied at the clock edge |
| acc_out | output | 16 | Accumulator value |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
The embedded properties rely on three things about the environment. `mem_rdata` must follow `mem_addr` within the cycle. Reset must be held for at least one edge before any program runs. The memory content must be fully defined. The harness meets these with a small array that is read combinationally and written on the edge. It loads each program only while reset is asserted. It ends every program with a halt and keeps code and data in separate, fully initialised regions. Expected accumulator and memory values, and the exact cycle of halt, are computed arithmetically over sweeps of operand values and over the unused opcodes.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_PREP   = 3'd2,
        PH_EXEC   = 3'd3,
        PH_HALT   = 3'd4
    } phase_e;

    typedef enum logic {
        ALU_ADD  = 1'b0,
        ALU_PASS = 1'b1
    } alu_op_e;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'h0;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'h1;
    localparam logic [OPC_W-1:0] OPC_SHR = 4'h2;
    localparam logic [OPC_W-1:0] OPC_SHL = 4'h3;
    localparam logic [OPC_W-1:0] OPC_CLR = 4'h4;
    localparam logic [OPC_W-1:0] OPC_LDA = 4'h5;
    localparam logic [OPC_W-1:0] OPC_STA = 4'h6;
    localparam logic [OPC_W-1:0] OPC_JZ  = 4'h7;
    localparam logic [OPC_W-1:0] OPC_HLT = 4'hF;

    typedef struct packed {
        logic    addr_sel;
        logic    ir_ld;
        logic    pc_inc;
        logic    pc_ld;
        logic    alu_set;
        alu_op_e alu_op;
        logic    acc_ld;
        logic    acc_shl;
        logic    acc_shr;
        logic    acc_clr;
        logic    mem_we;
        logic    halt_req;
    } ctrl_t;

endpackage

// File: rtl/cpu4_phase_gen.sv
module cpu4_phase_gen
    import cpu4_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   halt_req,
    output phase_e phase
);

    typedef struct packed {
        phase_e phase;
    } pg_s;

    pg_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_FETCH:  st_d.phase = PH_DECODE;
            PH_DECODE: st_d.phase = halt_req ? PH_HALT : PH_PREP;
            PH_PREP:   st_d.phase = PH_EXEC;
            PH_EXEC:   st_d.phase = PH_FETCH;
            PH_HALT:   st_d.phase = PH_HALT;
            default:   st_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{phase: PH_FETCH};
        else     st_q <= st_d;
    end

    assign phase = st_q.phase;

    p_fetch_next_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_FETCH) |=> (st_q.phase == PH_DECODE));
    p_decode_next_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_DECODE && !halt_req) |=> (st_q.phase == PH_PREP));
    p_prep_next_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_PREP) |=> (st_q.phase == PH_EXEC));
    p_exec_next_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_EXEC) |=> (st_q.phase == PH_FETCH));
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_HALT) |=> (st_q.phase == PH_HALT));

endmodule

// File: rtl/cpu4_decoder.sv
module cpu4_decoder
    import cpu4_pkg::*;
(
    input  phase_e             phase,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               acc_zero,
    output ctrl_t              ctrl
);

    always_comb begin
        ctrl = '0;
        case (phase)
            PH_FETCH: begin
                ctrl.addr_sel = 1'b0;
                ctrl.ir_ld    = 1'b1;
            end
            PH_DECODE: begin
                ctrl.addr_sel = 1'b1;
                ctrl.pc_inc   = 1'b1;
                ctrl.halt_req = (opcode == OPC_HLT);
            end
            PH_PREP: begin
                ctrl.addr_sel = 1'b1;
                case (opcode)
                    OPC_ADD: begin
                        ctrl.alu_set = 1'b1;
                        ctrl.alu_op  = ALU_ADD;
                    end
                    OPC_LDA: begin
                        ctrl.alu_set = 1'b1;
                        ctrl.alu_op  = ALU_PASS;
                    end
                    OPC_JMP: ctrl.pc_ld = 1'b1;
                    OPC_JZ:  ctrl.pc_ld = acc_zero;
                    default: ;
                endcase
            end
            PH_EXEC: begin
                ctrl.addr_sel = 1'b1;
                case (opcode)
                    OPC_ADD, OPC_LDA: ctrl.acc_ld  = 1'b1;
                    OPC_SHR:          ctrl.acc_shr = 1'b1;
                    OPC_SHL:          ctrl.acc_shl = 1'b1;
                    OPC_CLR:          ctrl.acc_clr = 1'b1;
                    OPC_STA:          ctrl.mem_we  = 1'b1;
                    default: ;
                endcase
            end
            PH_HALT: ctrl.addr_sel = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu4_datapath.sv
module cpu4_datapath
    import cpu4_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OPC_W-1:0]  opcode,
    output logic              acc_zero,
    output logic [DATA_W-1:0] acc
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        alu_op_e           alu;
    } dp_s;

    dp_s dp_d, dp_q;
    logic [DATA_W-1:0] alu_res;

    assign alu_res = (dp_q.alu == ALU_ADD) ? (dp_q.acc + mem_rdata) : mem_rdata;

    always_comb begin
        dp_d = dp_q;
        if (ctrl.ir_ld)   dp_d.ir  = mem_rdata;
        if (ctrl.pc_inc)  dp_d.pc  = dp_q.pc + 1'b1;
        if (ctrl.pc_ld)   dp_d.pc  = dp_q.ir[ADDR_W-1:0];
        if (ctrl.alu_set) dp_d.alu = ctrl.alu_op;
        if (ctrl.acc_clr)      dp_d.acc = '0;
        else if (ctrl.acc_ld)  dp_d.acc = alu_res;
        else if (ctrl.acc_shl) dp_d.acc = {dp_q.acc[DATA_W-2:0], 1'b0};
        else if (ctrl.acc_shr) dp_d.acc = {1'b0, dp_q.acc[DATA_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign mem_addr  = ctrl.addr_sel ? dp_q.ir[ADDR_W-1:0] : dp_q.pc;
    assign mem_wdata = dp_q.acc;
    assign opcode    = dp_q.ir[DATA_W-1 -: OPC_W];
    assign acc_zero  = (dp_q.acc == '0);
    assign acc       = dp_q.acc;

    p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pc_inc && !ctrl.pc_ld) |=> (dp_q.pc == $past(dp_q.pc) + 1'b1));
    p_pc_jump_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl.pc_ld |=> (dp_q.pc == $past(dp_q.ir[ADDR_W-1:0])));
    p_acc_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.acc_ld || ctrl.acc_shl || ctrl.acc_shr || ctrl.acc_clr)
        |=> $stable(dp_q.acc));
    p_acc_clear_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl.acc_clr |=> (dp_q.acc == '0));

endmodule

// File: rtl/cpu4_core.sv
module cpu4_core
    import cpu4_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = DATA_W - OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] acc_out,
    output logic              halted
);

    phase_e            phase;
    ctrl_t             ctrl;
    logic [OPC_W-1:0]  opcode;
    logic              acc_zero;

    cpu4_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .halt_req (ctrl.halt_req),
        .phase    (phase)
    );

    cpu4_decoder u_dec (
        .phase    (phase),
        .opcode   (opcode),
        .acc_zero (acc_zero),
        .ctrl     (ctrl)
    );

    cpu4_datapath #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode),
        .acc_zero  (acc_zero),
        .acc       (acc_out)
    );

    assign mem_we = ctrl.mem_we;
    assign halted = (phase == PH_HALT);

    p_we_single_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);
    p_acc_strobes_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl.acc_ld, ctrl.acc_shl, ctrl.acc_shr, ctrl.acc_clr, ctrl.mem_we}));
    p_halt_acc_stable_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(acc_out));

endmodule

// File: tb/cpu4_core_tb.sv
module cpu4_core_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata, mem_wdata, acc_out;
    logic        mem_we, halted;

    logic [15:0] mem [256];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int total = 0;
    int bad = 0;

    cpu4_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .acc_out   (acc_out),
        .halted    (halted)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic poke(input logic [7:0] a, input logic [15:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_area();
        for (int i = 0; i < 16; i++) poke(8'(i), 16'hF000);
        for (int i = 8'h80; i < 8'h88; i++) poke(8'(i), 16'h0000);
    endtask

    // k: index of the halt among executed instructions
    task automatic run(input int k, output int we_n);
        int n;
        logic [15:0] a0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(acc_out == 16'h0 && !halted && mem_addr == 12'h0 && !mem_we, "R11 reset state",
            {acc_out, 3'b0, halted, mem_addr}, 32'h0);
        rst = 1'b0;
        n = 0;
        we_n = 0;
        chk(mem_addr == 12'h0, "R2 fetch address", mem_addr, 0);
        while (!halted && n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) chk(mem_addr == mem[0][11:0], "R3 decode address", mem_addr, mem[0][11:0]);
            if (mem_we) begin
                we_n++;
                chk(mem_wdata == acc_out, "R7 write data", mem_wdata, acc_out);
            end
        end
        chk(n == 4 * k + 2, "R1 cycles to halt", n, 4 * k + 2);
        a0 = acc_out;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(halted && !mem_we && acc_out == a0, "R9 halted hold",
                {acc_out, 14'b0, halted, mem_we}, {a0, 16'h2});
        end
    endtask

    logic [15:0] vals [8];

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int wn;
        logic [15:0] e;
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'h00FF, 16'hAAAA};
        @(negedge clk);

        // R4 add sweep, R7 load/store
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                rst = 1'b1;
                clear_area();
                poke(8'h00, ins(4'h5, 12'h080));
                poke(8'h01, ins(4'h0, 12'h081));
                poke(8'h02, ins(4'h6, 12'h082));
                poke(8'h80, vals[i]);
                poke(8'h81, vals[j]);
                run(3, wn);
                e = vals[i] + vals[j];
                chk(mem[8'h82] == e, "R4 add stored", mem[8'h82], e);
                chk(acc_out == e, "R4 add acc", acc_out, e);
                chk(wn == 1, "R7 one write", wn, 1);
            end
        end

        // R6 shifts and R7 store of each result
        for (int i = 0; i < 8; i++) begin
            rst = 1'b1;
            clear_area();
            poke(8'h00, ins(4'h5, 12'h080));
            poke(8'h01, ins(4'h3, 12'h000));
            poke(8'h02, ins(4'h6, 12'h082));
            poke(8'h03, ins(4'h5, 12'h080));
            poke(8'h04, ins(4'h2, 12'h000));
            poke(8'h05, ins(4'h6, 12'h083));
            poke(8'h80, vals[i]);
            run(6, wn);
            chk(mem[8'h82] == {vals[i][14:0], 1'b0}, "R6 shift left", mem[8'h82], {vals[i][14:0], 1'b0});
            chk(mem[8'h83] == {1'b0, vals[i][15:1]}, "R6 shift right", mem[8'h83], {1'b0, vals[i][15:1]});
            chk(wn == 2, "R7 two writes", wn, 2);
        end

        // R6 clear
        for (int i = 0; i < 8; i++) begin
            rst = 1'b1;
            clear_area();
            poke(8'h00, ins(4'h5, 12'h080));
            poke(8'h01, ins(4'h4, 12'h000));
            poke(8'h02, ins(4'h6, 12'h082));
            poke(8'h80, vals[i]);
            poke(8'h82, 16'h5A5A);
            run(3, wn);
            chk(mem[8'h82] == 16'h0, "R6 clear", mem[8'h82], 0);
        end

        // R5 unconditional jump skips a clear
        for (int i = 0; i < 8; i++) begin
            rst = 1'b1;
            clear_area();
            poke(8'h00, ins(4'h5, 12'h080));
            poke(8'h01, ins(4'h1, 12'h003));
            poke(8'h02, ins(4'h4, 12'h000));
            poke(8'h03, ins(4'h6, 12'h082));
            poke(8'h80, vals[i]);
            poke(8'h82, 16'h1111);
            run(3, wn);
            chk(mem[8'h82] == vals[i], "R5 jump target", mem[8'h82], vals[i]);
        end

        // R8 zero-test jump
        for (int i = 0; i < 8; i++) begin
            rst = 1'b1;
            clear_area();
            poke(8'h00, ins(4'h5, 12'h080));
            poke(8'h01, ins(4'h7, 12'h003));
            poke(8'h02, ins(4'h5, 12'h081));
            poke(8'h03, ins(4'h6, 12'h082));
            poke(8'h80, vals[i]);
            poke(8'h81, 16'hBEEF);
            poke(8'h82, 16'h1111);
            run((vals[i] == 16'h0) ? 3 : 4, wn);
            e = (vals[i] == 16'h0) ? 16'h0000 : 16'hBEEF;
            chk(mem[8'h82] == e, "R8 zero jump", mem[8'h82], e);
        end

        // R10 unused opcodes
        for (int op = 8; op < 15; op++) begin
            rst = 1'b1;
            clear_area();
            poke(8'h00, ins(4'h5, 12'h080));
            poke(8'h01, ins(4'(op), 12'h081));
            poke(8'h02, ins(4'h6, 12'h082));
            poke(8'h80, 16'h1357);
            poke(8'h81, 16'h0F0F);
            run(3, wn);
            chk(mem[8'h82] == 16'h1357 && acc_out == 16'h1357, "R10 unused opcode acc", mem[8'h82], 16'h1357);
            chk(wn == 1 && mem[8'h81] == 16'h0F0F, "R10 unused opcode memory", mem[8'h81], 16'h0F0F);
        end

        summary();
        $finish;
    end

endmodule